// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

The block keeps three eight-bit records for a bank of interrupt lines. The pending record holds latched requests. The in-service record holds lines whose handlers are running. The mask record holds lines that are blocked. From these it picks the most urgent request that may interrupt the processor and raises a single interrupt line. Alongside that line it gives the chosen pin and a vector made from a programmable base.

The processor side replies with an acknowledge strobe that names the pin it took. Later it issues end-of-interrupt commands, which retire in-service pins and can rotate the priority order. A separate command decoder, outside this block, supplies the mask, the vector base and two mode bits:
- automatic end-of-interrupt;
- nested mode, in which the in-service bit of the cascade pin does not block other requests.

Requests arrive already conditioned as set pulses. The current input level is also supplied, so that an acknowledge can tell whether the line is still asserted.

Top module: `irq_resolver`

## Requirements
- R1: A synchronous active-high reset clears the pending, in-service and mask records, the priority base, the rotate flag, both mode bits and the vector base. After reset `irq_out` is 0, `irq_pin` is 0 and `irq_vector` is 0.
- R2: Priority follows a scan of steps i = 0..7. Step i visits pin ((i + 7 - base) mod 8), and an earlier step is more urgent. With base 0 the order is 7, 0, 1, 2, 3, 4, 5, 6.
- R3: A pin is eligible only when all three of these hold: its pending bit is set, its mask bit is clear, and its scan step comes before the step of the first in-service pin met in the scan. The candidate is the eligible pin with the earliest step.
- R4: With nested mode set (`cfg_nested` = 1), in-service bit 2 is left out of the blocking comparison of R3.
- R5: At the clock edge where a candidate exists and no interrupt is raised, `irq_out` becomes 1 from that edge. It stays 1 until the edge that samples `ack_valid` = 1, and after that edge it is 0 for at least one cycle.
- R6: On acknowledge of pin p, pending bit p is cleared only when `line_level[p]` is 0. A `req_set` bit that is high in the same cycle sets its pending bit regardless.
- R7: On acknowledge with automatic end-of-interrupt off, in-service bit p is set. With it on, the in-service record is untouched, and the priority base is loaded with p if the stored rotate flag is 1.
- R8: An end-of-interrupt command (`cmd_eoi` = 1) works in one of two ways. Non-specific (`cmd_specific` = 0) clears the most urgent set in-service bit in R2 order, and does nothing when none is set. Specific (`cmd_specific` = 1) clears in-service bit `cmd_level`. Whichever bit is cleared, `cmd_rotate` = 1 loads the priority base with that pin.
- R9: Every command stores `cmd_rotate` as the rotate flag. A command with `cmd_eoi` = 0, `cmd_specific` = 1 and `cmd_rotate` = 1 loads the priority base with `cmd_level`.
- R10: Each edge registers `irq_pin` as the candidate, or 7 when none exists. It also registers `irq_vector` as the vector base with its low 3 bits zeroed, plus that pin.
- R11: A `cfg_we` pulse loads the mask, vector base and both mode bits. A masked request never becomes the candidate.
- R12: Within one cycle the acknowledge is applied first, then the command, using the state left by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | LINES | Request set pulses, one per pin |
| line_level | input | LINES | Present asserted state of each input |
| cfg_we | input | 1 | Load configuration |
| cfg_mask | input | LINES | Mask value (1 blocks the pin) |
| cfg_base | input | VEC_W | Vector base |
| cfg_auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| cfg_nested | input | 1 | Nested mode for the cascade pin |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_pin | input | PIN_W | Acknowledged pin |
| cmd_valid | input | 1 | Command strobe |
| cmd_eoi | input | 1 | Command is an end-of-interrupt |
| cmd_specific | input | 1 | Command names a pin |
| cmd_rotate | input | 1 | Rotate flag carried by the command |
| cmd_level | input | PIN_W | Pin named by the command |
| irq_out | output | 1 | Interrupt raised |
| irq_pin | output | PIN_W | Candidate pin, or 7 when none |
| irq_vector | output | VEC_W | Vector for `irq_pin` |

## Verification
The bench first tries single requests, simultaneous requests and masked requests at the reset priority base, which shows whether the scan order and the mask are right. Next it raises a request while another pin is in service, with nested mode off and then on. This separates the blocking rule from the cascade exemption. Directed acknowledge and end-of-interrupt sequences cover both modes, held and released input levels, specific and non-specific retirement, and rotation. A long random stretch then mixes every input in the same cycle, which exposes ordering errors between acknowledge, command and request.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_VEC_W   = 8;
  localparam int unsigned DEF_CASCADE = 2;

  typedef enum logic [1:0] {
    CMD_NONE      = 2'd0,
    CMD_EOI_AUTO  = 2'd1,
    CMD_EOI_NAMED = 2'd2,
    CMD_SET_BASE  = 2'd3
  } cmd_kind_e;

  function automatic cmd_kind_e classify_cmd(input logic valid, input logic eoi,
                                             input logic specific, input logic rotate);
    if (!valid)                     return CMD_NONE;
    if (eoi && specific)            return CMD_EOI_NAMED;
    if (eoi)                        return CMD_EOI_AUTO;
    if (specific && rotate)         return CMD_SET_BASE;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/irq_rank_scan.sv
module irq_rank_scan #(
  parameter int unsigned LINES = 8,
  parameter int unsigned PIN_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] vec,
  input  logic [PIN_W-1:0] base_prio,
  output logic             found,
  output logic [PIN_W-1:0] step,
  output logic [PIN_W-1:0] pin
);
  localparam logic [PIN_W-1:0] LAST = PIN_W'(LINES - 1);

  logic [LINES-1:0] ordered;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_order
      localparam logic [PIN_W-1:0] OFF = PIN_W'(g + LINES - 1);
      logic [PIN_W-1:0] src;
      assign src        = OFF - base_prio;
      assign ordered[g] = vec[src];
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    step  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (ordered[i]) begin
        found = 1'b1;
        step  = PIN_W'(i);
      end
    end
    pin = step + LAST - base_prio;
  end
endmodule

// File: rtl/irq_eligible.sv
module irq_eligible #(
  parameter int unsigned LINES   = 8,
  parameter int unsigned PIN_W   = $clog2(LINES),
  parameter int unsigned CASCADE = 2
) (
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] serv,
  input  logic [PIN_W-1:0] base_prio,
  input  logic             nested,
  output logic             valid,
  output logic [PIN_W-1:0] pin
);
  localparam logic [PIN_W-1:0] LAST = PIN_W'(LINES - 1);

  logic [LINES-1:0] serv_eff;
  logic             blk_found;
  logic [PIN_W-1:0] blk_step;
  logic [PIN_W-1:0] blk_pin;
  logic [LINES-1:0] allowed;
  logic [LINES-1:0] cand;
  logic [PIN_W-1:0] cand_step;

  always_comb begin
    serv_eff = serv;
    if (nested) serv_eff[CASCADE] = 1'b0;
  end

  irq_rank_scan #(.LINES(LINES), .PIN_W(PIN_W)) u_block (
    .vec(serv_eff), .base_prio(base_prio),
    .found(blk_found), .step(blk_step), .pin(blk_pin)
  );

  generate
    for (genvar p = 0; p < LINES; p++) begin : g_rank
      logic [PIN_W-1:0] rank;
      assign rank       = PIN_W'(p) - LAST + base_prio;
      assign allowed[p] = !blk_found || (rank < blk_step);
    end
  endgenerate

  assign cand = pend & ~mask & allowed;

  irq_rank_scan #(.LINES(LINES), .PIN_W(PIN_W)) u_pick (
    .vec(cand), .base_prio(base_prio),
    .found(valid), .step(cand_step), .pin(pin)
  );
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned LINES   = DEF_LINES,
  parameter int unsigned VEC_W   = DEF_VEC_W,
  parameter int unsigned CASCADE = DEF_CASCADE,
  parameter int unsigned PIN_W   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_set,
  input  logic [LINES-1:0] line_level,
  input  logic             cfg_we,
  input  logic [LINES-1:0] cfg_mask,
  input  logic [VEC_W-1:0] cfg_base,
  input  logic             cfg_auto_eoi,
  input  logic             cfg_nested,
  input  logic             ack_valid,
  input  logic [PIN_W-1:0] ack_pin,
  input  logic             cmd_valid,
  input  logic             cmd_eoi,
  input  logic             cmd_specific,
  input  logic             cmd_rotate,
  input  logic [PIN_W-1:0] cmd_level,
  output logic             irq_out,
  output logic [PIN_W-1:0] irq_pin,
  output logic [VEC_W-1:0] irq_vector
);
  localparam logic [PIN_W-1:0] SPURIOUS = PIN_W'(LINES - 1);

  logic [LINES-1:0] irr_q, isr_q, imr_q;
  logic [PIN_W-1:0] prio_q;
  logic [VEC_W-1:0] base_q;
  logic             aeoi_q, sfn_q, rot_q, raised_q;
  logic [PIN_W-1:0] pin_q;
  logic [VEC_W-1:0] vec_q;

  logic             elig_valid;
  logic [PIN_W-1:0] elig_pin;
  logic [PIN_W-1:0] pin_next;

  logic [LINES-1:0] irr_n, isr_a, isr_n;
  logic [PIN_W-1:0] prio_a, prio_n;
  logic             rot_n;
  logic             hi_found;
  logic [PIN_W-1:0] hi_step, hi_pin;
  cmd_kind_e        kind;

  irq_eligible #(.LINES(LINES), .PIN_W(PIN_W), .CASCADE(CASCADE)) u_elig (
    .pend(irr_q), .mask(imr_q), .serv(isr_q), .base_prio(prio_q),
    .nested(sfn_q), .valid(elig_valid), .pin(elig_pin)
  );

  // acknowledge stage, then request latching
  always_comb begin
    irr_n  = irr_q;
    isr_a  = isr_q;
    prio_a = prio_q;
    if (ack_valid) begin
      if (!line_level[ack_pin]) irr_n[ack_pin] = 1'b0;
      if (aeoi_q) begin
        if (rot_q) prio_a = ack_pin;
      end else begin
        isr_a[ack_pin] = 1'b1;
      end
    end
    irr_n = irr_n | req_set;
  end

  irq_rank_scan #(.LINES(LINES), .PIN_W(PIN_W)) u_hi (
    .vec(isr_a), .base_prio(prio_a),
    .found(hi_found), .step(hi_step), .pin(hi_pin)
  );

  // command stage, on the state left by the acknowledge
  always_comb begin
    isr_n  = isr_a;
    prio_n = prio_a;
    rot_n  = cmd_valid ? cmd_rotate : rot_q;
    kind   = classify_cmd(cmd_valid, cmd_eoi, cmd_specific, cmd_rotate);
    unique case (kind)
      CMD_EOI_NAMED: begin
        isr_n[cmd_level] = 1'b0;
        if (cmd_rotate) prio_n = cmd_level;
      end
      CMD_EOI_AUTO: begin
        if (hi_found) begin
          isr_n[hi_pin] = 1'b0;
          if (cmd_rotate) prio_n = hi_pin;
        end
      end
      CMD_SET_BASE: prio_n = cmd_level;
      default: ;
    endcase
  end

  assign pin_next = elig_valid ? elig_pin : SPURIOUS;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q    <= '0;
      isr_q    <= '0;
      imr_q    <= '0;
      prio_q   <= '0;
      base_q   <= '0;
      aeoi_q   <= 1'b0;
      sfn_q    <= 1'b0;
      rot_q    <= 1'b0;
      raised_q <= 1'b0;
      pin_q    <= '0;
      vec_q    <= '0;
    end else begin
      irr_q    <= irr_n;
      isr_q    <= isr_n;
      prio_q   <= prio_n;
      rot_q    <= rot_n;
      raised_q <= ack_valid ? 1'b0 : (raised_q | elig_valid);
      pin_q    <= pin_next;
      vec_q    <= {base_q[VEC_W-1:PIN_W], pin_next};
      if (cfg_we) begin
        imr_q  <= cfg_mask;
        base_q <= cfg_base;
        aeoi_q <= cfg_auto_eoi;
        sfn_q  <= cfg_nested;
      end
    end
  end

  assign irq_out    = raised_q;
  assign irq_pin    = pin_q;
  assign irq_vector = vec_q;
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned LINES = 8,
  parameter int unsigned PIN_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] req_set,
  input logic             ack_valid,
  input logic [PIN_W-1:0] ack_pin,
  input logic             cmd_valid,
  input logic             irq_out,
  input logic [LINES-1:0] irr_q,
  input logic [LINES-1:0] isr_q,
  input logic             aeoi_q
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_out && isr_q == '0 && irr_q == '0)); // R1

  AST_RAISED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_valid) |=> irq_out); // R5

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> !irq_out); // R5

  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (|req_set) |=> ((irr_q & $past(req_set)) == $past(req_set))); // R6

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !aeoi_q && !cmd_valid) |=> isr_q[$past(ack_pin)]); // R7

  AST_AUTO_EOI_NO_MARK: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && aeoi_q && !isr_q[ack_pin]) |=> !isr_q[$past(ack_pin)]); // R7
endmodule

bind irq_resolver irq_resolver_chk #(.LINES(LINES), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .req_set(req_set), .ack_valid(ack_valid),
  .ack_pin(ack_pin), .cmd_valid(cmd_valid), .irq_out(irq_out),
  .irr_q(irr_q), .isr_q(isr_q), .aeoi_q(aeoi_q)
);

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_set = '0, line_level = '0, cfg_mask = '0, cfg_base = '0;
  logic       cfg_we = 0, cfg_auto_eoi = 0, cfg_nested = 0;
  logic       ack_valid = 0, cmd_valid = 0, cmd_eoi = 0, cmd_specific = 0, cmd_rotate = 0;
  logic [2:0] ack_pin = '0, cmd_level = '0;
  logic       irq_out;
  logic [2:0] irq_pin;
  logic [7:0] irq_vector;

  int    vectors = 0, miscompares = 0;
  string tag = "R1";
  bit    done = 0;

  // reference state
  bit [7:0] m_irr, m_isr, m_imr, m_base;
  int       m_prio;
  bit       m_rot, m_aeoi, m_sfn, m_raised;
  bit       e_irq;
  int       e_pin;
  int       e_vec;

  always #5 clk = ~clk;

  irq_resolver uut (
    .clk(clk), .rst(rst), .req_set(req_set), .line_level(line_level),
    .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_base(cfg_base),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_nested(cfg_nested),
    .ack_valid(ack_valid), .ack_pin(ack_pin), .cmd_valid(cmd_valid),
    .cmd_eoi(cmd_eoi), .cmd_specific(cmd_specific), .cmd_rotate(cmd_rotate),
    .cmd_level(cmd_level), .irq_out(irq_out), .irq_pin(irq_pin),
    .irq_vector(irq_vector)
  );

  function automatic int order_pin(int i, int pr);
    return (i + 7 - pr) % 8;
  endfunction

  function automatic int first_set(bit [7:0] v, int pr);
    for (int i = 0; i < 8; i++) if (v[order_pin(i, pr)]) return order_pin(i, pr);
    return -1;
  endfunction

  function automatic int best_request();
    bit [7:0] blk = m_isr;
    int stop = 8;
    if (m_sfn) blk[2] = 0;
    for (int i = 0; i < 8; i++) if (blk[order_pin(i, m_prio)]) begin stop = i; break; end
    for (int j = 0; j < stop; j++) begin
      int p = order_pin(j, m_prio);
      if (m_irr[p] && !m_imr[p]) return p;
    end
    return -1;
  endfunction

  task automatic model_step();
    int e, tgt;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_prio = 0;
      m_rot = 0; m_aeoi = 0; m_sfn = 0; m_raised = 0;
      e_irq = 0; e_pin = 0; e_vec = 0;
      return;
    end
    e = best_request();
    e_pin = (e >= 0) ? e : 7;
    e_vec = (m_base & 8'hF8) + e_pin;
    m_raised = ack_valid ? 0 : (m_raised || e >= 0);
    e_irq = m_raised;
    if (ack_valid) begin
      if (!line_level[ack_pin]) m_irr[ack_pin] = 0;
      if (m_aeoi) begin if (m_rot) m_prio = ack_pin; end
      else m_isr[ack_pin] = 1;
    end
    m_irr |= req_set;
    if (cmd_valid) begin
      m_rot = cmd_rotate;
      if (cmd_eoi) begin
        tgt = cmd_specific ? int'(cmd_level) : first_set(m_isr, m_prio);
        if (tgt >= 0) begin
          m_isr[tgt] = 0;
          if (cmd_rotate) m_prio = tgt;
        end
      end else if (cmd_specific && cmd_rotate) m_prio = cmd_level;
    end
    if (cfg_we) begin
      m_imr = cfg_mask; m_base = cfg_base; m_aeoi = cfg_auto_eoi; m_sfn = cfg_nested;
    end
  endtask

  task automatic compare();
    vectors++;
    if (irq_out !== e_irq || int'(irq_pin) != e_pin || int'(irq_vector) != e_vec) begin
      miscompares++;
      $display("FAIL %s: irq_out=%0b pin=%0d vector=%0h, expected irq_out=%0b pin=%0d vector=%0h",
               tag, irq_out, irq_pin, irq_vector, e_irq, e_pin, e_vec);
    end
  endtask

  task automatic clear_pulses();
    req_set = 0; cfg_we = 0; ack_valid = 0; cmd_valid = 0;
    cmd_eoi = 0; cmd_specific = 0; cmd_rotate = 0;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    clear_pulses();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic configure(bit [7:0] mask, bit [7:0] base, bit aeoi, bit nest);
    cfg_we = 1; cfg_mask = mask; cfg_base = base; cfg_auto_eoi = aeoi; cfg_nested = nest;
    tick();
  endtask

  task automatic acknowledge(int p);
    ack_valid = 1; ack_pin = 3'(p); tick();
  endtask

  task automatic command(bit eoi, bit spec, bit rot, int lvl);
    cmd_valid = 1; cmd_eoi = eoi; cmd_specific = spec; cmd_rotate = rot; cmd_level = 3'(lvl);
    tick();
  endtask

  task automatic do_reset();
    rst = 1; idle(2); rst = 0;
  endtask

  initial begin
    // R1: reset state
    tag = "R1"; idle(3); rst = 0;
    tag = "R11"; configure(8'h00, 8'h20, 0, 0);
    // R2, R10: pins 7 and 0 together at base 0, pin 7 first
    tag = "R2"; req_set = 8'h81; tick(); idle(3);
    tag = "R7"; acknowledge(7); idle(2);
    tag = "R3"; acknowledge(0); idle(2);       // 0 ranks after 7 while 7 in service
    tag = "R8"; command(1, 0, 0, 0); idle(2);  // non-specific clears pin 7
    acknowledge(0); command(1, 0, 0, 0); idle(2);
    tag = "R8"; command(1, 0, 0, 0); idle(2);  // nothing in service
    // R11: masked request stays out
    tag = "R11"; configure(8'h10, 8'h20, 0, 0); req_set = 8'h10; tick(); idle(3);
    configure(8'h00, 8'h40, 0, 0); idle(3);
    tag = "R10"; acknowledge(4); command(1, 1, 0, 4); idle(2);
    // R3/R4: pin 2 in service blocks pin 3 unless nested
    tag = "R3"; req_set = 8'h04; tick(); idle(2); acknowledge(2); idle(1);
    req_set = 8'h08; tick(); idle(3);
    tag = "R4"; configure(8'h00, 8'h40, 0, 1); idle(3);
    acknowledge(3); command(1, 1, 0, 3); command(1, 1, 0, 2); idle(2);
    // R6: held level keeps the request pending
    tag = "R6"; line_level = 8'h02; req_set = 8'h02; tick(); idle(2);
    acknowledge(1); command(1, 0, 0, 0); idle(3);
    line_level = 0; acknowledge(1); command(1, 0, 0, 0); idle(2);
    // R6: same-cycle set while acknowledging
    req_set = 8'h20; tick(); idle(2);
    req_set = 8'h20; ack_valid = 1; ack_pin = 3'd5; tick(); idle(2);
    command(1, 0, 0, 0); acknowledge(5); command(1, 0, 0, 0); idle(2);
    // R9: priority base set, then R2 order under the new base
    tag = "R9"; command(0, 1, 1, 4); req_set = 8'h19; tick(); idle(3);
    acknowledge(3); command(1, 0, 1, 0); idle(3);
    // R7: automatic end-of-interrupt with rotation
    tag = "R7"; configure(8'h00, 8'h80, 1, 0); command(0, 0, 1, 0);
    req_set = 8'hC0; tick(); idle(2); acknowledge(6); idle(3); acknowledge(7); idle(2);
    // R12: acknowledge and end-of-interrupt in one cycle
    tag = "R12"; configure(8'h00, 8'h80, 0, 0); req_set = 8'h01; tick(); idle(2);
    ack_valid = 1; ack_pin = 3'd0; cmd_valid = 1; cmd_eoi = 1; tick(); idle(2);
    tag = "R1"; do_reset(); idle(2);
    // mixed random traffic
    tag = "R3 random";
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) begin
        configure(8'($urandom_range(0, 255)) & 8'h6F, 8'($urandom_range(0, 255)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end else begin
        req_set    = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
        line_level = ($urandom_range(0, 4) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
        if (irq_out && $urandom_range(0, 2) == 0) begin
          ack_valid = 1; ack_pin = irq_pin;
        end
        if ($urandom_range(0, 5) == 0) begin
          cmd_valid = 1; cmd_eoi = 1'($urandom_range(0, 3) != 0);
          cmd_specific = 1'($urandom_range(0, 1)); cmd_rotate = 1'($urandom_range(0, 1));
          cmd_level = 3'($urandom_range(0, 7));
        end
        if (n % 1000 == 999) rst = 1;
        tick();
        rst = 0;
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule